// File: doc/BRIEF.md
# Random memory tag insertion unit

This execute-stage unit serves the tag-insertion instruction of a memory-tagging scheme. It recognises the instruction's fixed 32-bit pattern, reports the destination, base and exclusion register indexes, and flags the indexes that name the stack pointer or the zero register. For an executed instruction it takes the base operand and replaces its 4-bit logical tag field with a freshly chosen tag. A tag is never picked if it is named in the merged exclude mask. That mask is the low 16 bits of the exclusion operand combined with a system-wide exclude mask.

The tag choice depends on a mode select. In deterministic mode a stored tag state is advanced by a pseudo-random offset, the tag skips forward past excluded values, and the chosen tag is written back as the new state. In random mode the pseudo-random value alone is the starting candidate. If tag access is disabled, or every tag is excluded, the tag is forced to zero. When the tagging feature is switched off, a matching instruction raises an undefined-instruction flag and changes nothing. The register file and the tag state register itself live outside the unit. The unit reads the state through an input and returns the write-back through an output strobe.

Top module: `mtag_insert`

## Requirements
- R1: An instruction matches (`hit_o`=1) exactly when bits 31:21 equal 10011010110 and bits 15:10 equal 000100. The destination index is bits 4:0, the base index is bits 9:5 and the exclusion index is bits 20:16. `rd_is_sp_o` and `rn_is_sp_o` are 1 when their index is 31. `rm_is_zero_o` is 1 when the exclusion index is 31.
- R2: The merged exclude mask is the system mask ORed with bits 15:0 of the exclusion operand. Bit t set means tag t is excluded. When the exclusion index is 31, the exclusion operand is taken as all zeros and its value has no effect.
- R3: An executed instruction (issue, hit and feature enabled) produces `res_valid_o`=1 on the next cycle. `result_o` then equals the base operand with bits 59:56 replaced by the chosen tag, and every other bit is unchanged.
- R4: When tag access is disabled, the inserted tag is 0 and `state_we_o` stays 0.
- R5: In deterministic mode (`rand_mode_i`=0) the first candidate is (tag state + offset) mod 16. The unit steps upward by one, wrapping mod 16, until it finds a tag that is not excluded. It then asserts `state_we_o` with `state_o` equal to that tag. If all 16 tags are excluded, the tag is 0 and 0 is written back.
- R6: In random mode (`rand_mode_i`=1) the first candidate is the offset itself, with the same upward skipping. If all 16 tags are excluded the tag is 0. `state_we_o` stays 0.
- R7: The offset is bits 3:0 of a 16-bit LFSR. The LFSR is seeded with 0xACE1 at reset. Its next value is {q[14:0], q[15]^q[13]^q[12]^q[10]}. An instruction uses the value held before it executes, and the LFSR advances exactly once for each executed instruction.
- R8: A matching instruction issued with the feature disabled raises `undef_o` on the next cycle. In that cycle `res_valid_o` and `state_we_o` stay 0, and the LFSR does not advance.
- R9: An issued word that does not match produces no valid result, no undefined flag and no state write, and it does not advance the LFSR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| issue_i | input | 1 | Instruction word presented for execution this cycle |
| insn_i | input | 32 | Instruction word |
| feat_en_i | input | 1 | Tagging feature enable |
| tag_access_en_i | input | 1 | Allocation tag access enabled at the current level |
| rand_mode_i | input | 1 | 1 = random mode, 0 = deterministic mode |
| sys_excl_i | input | 16 | System exclude mask |
| base_op_i | input | 64 | Base address operand |
| excl_op_i | input | 64 | Exclusion operand (low 16 bits used) |
| tag_state_i | input | 4 | Current tag state |
| hit_o | output | 1 | Instruction pattern match |
| rd_idx_o | output | 5 | Destination register index |
| rn_idx_o | output | 5 | Base register index |
| rm_idx_o | output | 5 | Exclusion register index |
| rd_is_sp_o | output | 1 | Destination is the stack pointer |
| rn_is_sp_o | output | 1 | Base is the stack pointer |
| rm_is_zero_o | output | 1 | Exclusion source is the zero register |
| res_valid_o | output | 1 | Result valid strobe |
| result_o | output | 64 | Tagged address |
| state_we_o | output | 1 | Tag state write strobe |
| state_o | output | 4 | New tag state value |
| undef_o | output | 1 | Undefined-instruction flag |

## Verification
In deterministic mode, the all-excluded zero forcing and the state write-back happen in the same cycle. The bench provokes this by sweeping every start state against an all-ones merged mask, split between the system mask and the exclusion operand. It expects a zero tag in `result_o` together with a write of 0 on `state_o`. The undefined-instruction path and the LFSR are checked together: a disabled-feature issue sits between two executed instructions. Only an LFSR that did not advance predicts the tag of the second instruction, and the bench's own model predicts every tag.

// File: rtl/mtag_pkg.sv
package mtag_pkg;
  localparam int REG_IDX_W = 5;
  localparam logic [REG_IDX_W-1:0] SP_IDX = 5'd31;
  localparam logic [10:0] OPC_HI  = 11'b10011010110;
  localparam logic [5:0]  OPC_MID = 6'b000100;

  typedef struct packed {
    logic                 hit;
    logic [REG_IDX_W-1:0] rm;
    logic [REG_IDX_W-1:0] rn;
    logic [REG_IDX_W-1:0] rd;
  } insn_fields_t;
endpackage

// File: rtl/mtag_decode.sv
module mtag_decode
  import mtag_pkg::*;
(
  input  logic [31:0]  insn_i,
  output insn_fields_t fld_o
);
  always_comb begin
    fld_o.hit = (insn_i[31:21] == OPC_HI) && (insn_i[15:10] == OPC_MID);
    fld_o.rm  = insn_i[20:16];
    fld_o.rn  = insn_i[9:5];
    fld_o.rd  = insn_i[4:0];
  end
endmodule

// File: rtl/mtag_lfsr.sv
module mtag_lfsr #(
  parameter int           W    = 16,
  parameter logic [W-1:0] SEED = 16'hACE1,
  parameter logic [W-1:0] TAPS = 16'hB400
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv_i,
  output logic [W-1:0] state_o
);
  logic [W-1:0] q;
  logic [W-1:0] q_next;

  always_comb begin
    q_next = {q[W-2:0], ^(q & TAPS)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= SEED;
    else if (adv_i) q <= q_next;
  end

  assign state_o = q;
endmodule

// File: rtl/mtag_pick.sv
module mtag_pick #(
  parameter int TAG_W = 4
) (
  input  logic [TAG_W-1:0]       start_i,
  input  logic [(1<<TAG_W)-1:0]  excl_i,
  output logic [TAG_W-1:0]       tag_o,
  output logic                   none_o
);
  localparam int N = 1 << TAG_W;

  logic [N-1:0]     free_rot;
  logic [TAG_W-1:0] step;

  for (genvar i = 0; i < N; i++) begin : g_rot
    logic [TAG_W-1:0] cand;
    assign cand        = start_i + TAG_W'(i);
    assign free_rot[i] = ~excl_i[cand];
  end

  always_comb begin
    step = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (free_rot[i]) step = TAG_W'(i);
    end
  end

  assign none_o = ~|free_rot;
  assign tag_o  = start_i + step;
endmodule

// File: rtl/mtag_insert.sv
module mtag_insert
  import mtag_pkg::*;
#(
  parameter int                DATA_W   = 64,
  parameter int                TAG_W    = 4,
  parameter int                TAG_LSB  = 56,
  parameter int                RND_W    = 16,
  parameter logic [RND_W-1:0]  RND_SEED = 16'hACE1,
  parameter logic [RND_W-1:0]  RND_TAPS = 16'hB400
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    issue_i,
  input  logic [31:0]             insn_i,
  input  logic                    feat_en_i,
  input  logic                    tag_access_en_i,
  input  logic                    rand_mode_i,
  input  logic [(1<<TAG_W)-1:0]   sys_excl_i,
  input  logic [DATA_W-1:0]       base_op_i,
  input  logic [DATA_W-1:0]       excl_op_i,
  input  logic [TAG_W-1:0]        tag_state_i,
  output logic                    hit_o,
  output logic [REG_IDX_W-1:0]    rd_idx_o,
  output logic [REG_IDX_W-1:0]    rn_idx_o,
  output logic [REG_IDX_W-1:0]    rm_idx_o,
  output logic                    rd_is_sp_o,
  output logic                    rn_is_sp_o,
  output logic                    rm_is_zero_o,
  output logic                    res_valid_o,
  output logic [DATA_W-1:0]       result_o,
  output logic                    state_we_o,
  output logic [TAG_W-1:0]        state_o,
  output logic                    undef_o
);
  localparam int N_TAGS = 1 << TAG_W;

  // reset synchronizer: async assert, sync release
  logic [1:0] rst_pipe;
  logic       rst_n_int;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_int = rst_pipe[1];

  insn_fields_t fld;
  mtag_decode u_dec (.insn_i(insn_i), .fld_o(fld));

  assign hit_o        = fld.hit;
  assign rd_idx_o     = fld.rd;
  assign rn_idx_o     = fld.rn;
  assign rm_idx_o     = fld.rm;
  assign rd_is_sp_o   = (fld.rd == SP_IDX);
  assign rn_is_sp_o   = (fld.rn == SP_IDX);
  assign rm_is_zero_o = (fld.rm == SP_IDX);

  logic exec, trap;
  assign exec = issue_i & fld.hit & feat_en_i;
  assign trap = issue_i & fld.hit & ~feat_en_i;

  logic [RND_W-1:0] rnd;
  mtag_lfsr #(.W(RND_W), .SEED(RND_SEED), .TAPS(RND_TAPS)) u_lfsr (
    .clk(clk), .rst_n(rst_n_int), .adv_i(exec), .state_o(rnd)
  );

  logic [N_TAGS-1:0] excl_src, excl_eff;
  logic [TAG_W-1:0]  offset, pick_start, pick_tag;
  logic              pick_none;

  assign excl_src   = rm_is_zero_o ? '0 : excl_op_i[N_TAGS-1:0];
  assign excl_eff   = excl_src | sys_excl_i;
  assign offset     = rnd[TAG_W-1:0];
  assign pick_start = rand_mode_i ? offset : tag_state_i + offset;

  mtag_pick #(.TAG_W(TAG_W)) u_pick (
    .start_i(pick_start), .excl_i(excl_eff), .tag_o(pick_tag), .none_o(pick_none)
  );

  logic              unused_bits;
  assign unused_bits = ^{excl_op_i[DATA_W-1:N_TAGS], rnd[RND_W-1:TAG_W]};

  // next-state
  logic [TAG_W-1:0]  tag_d;
  logic              we_d;
  logic [DATA_W-1:0] res_d;
  always_comb begin
    tag_d = '0;
    we_d  = 1'b0;
    if (tag_access_en_i) begin
      tag_d = pick_none ? '0 : pick_tag;
      we_d  = ~rand_mode_i;
    end
    res_d = base_op_i;
    res_d[TAG_LSB +: TAG_W] = tag_d;
  end

  // registers
  logic              valid_q, undef_q, we_q;
  logic [DATA_W-1:0] result_q;
  logic [TAG_W-1:0]  state_q;
  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      valid_q <= 1'b0;
      undef_q <= 1'b0;
      we_q    <= 1'b0;
    end else begin
      valid_q <= exec;
      undef_q <= trap;
      we_q    <= exec & we_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int)  result_q <= '0;
    else if (exec)   result_q <= res_d;
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int)         state_q <= '0;
    else if (exec && we_d)  state_q <= tag_d;
  end

  assign res_valid_o = valid_q;
  assign undef_o     = undef_q;
  assign state_we_o  = we_q;
  assign result_o    = result_q;
  assign state_o     = state_q;
endmodule

// File: rtl/mtag_insert_chk.sv
module mtag_insert_chk #(
  parameter int DATA_W  = 64,
  parameter int TAG_W   = 4,
  parameter int TAG_LSB = 56
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  issue_i,
  input logic                  tag_access_en_i,
  input logic                  rand_mode_i,
  input logic [(1<<TAG_W)-1:0] sys_excl_i,
  input logic [DATA_W-1:0]     base_op_i,
  input logic [DATA_W-1:0]     excl_op_i,
  input logic                  hit_o,
  input logic [4:0]            rm_idx_o,
  input logic                  res_valid_o,
  input logic [DATA_W-1:0]     result_o,
  input logic                  state_we_o,
  input logic [TAG_W-1:0]      state_o,
  input logic                  undef_o
);
  localparam int N_TAGS = 1 << TAG_W;
  localparam logic [DATA_W-1:0] FIELD = {{(DATA_W-TAG_W){1'b0}}, {TAG_W{1'b1}}} << TAG_LSB;

  logic [N_TAGS-1:0] mask_q;
  always_ff @(posedge clk) begin
    mask_q <= sys_excl_i | ((rm_idx_o == 5'd31) ? '0 : excl_op_i[N_TAGS-1:0]);
  end

  logic [TAG_W-1:0] out_tag;
  assign out_tag = result_o[TAG_LSB +: TAG_W];

  AST_UNDEF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    undef_o |-> !res_valid_o && !state_we_o); // R8
  AST_WRITE_IS_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    state_we_o |-> res_valid_o && state_o == out_tag); // R5
  AST_PASS_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_o |-> ((result_o ^ $past(base_op_i)) & ~FIELD) == '0); // R3
  AST_ACCESS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_o && !$past(tag_access_en_i) |-> out_tag == '0 && !state_we_o); // R4
  AST_TAG_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_o && $past(tag_access_en_i) && out_tag != '0 |-> !mask_q[out_tag]); // R2
  AST_RANDOM_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_o && $past(rand_mode_i) |-> !state_we_o); // R6
  AST_VALID_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_o |-> $past(issue_i && hit_o)); // R9
endmodule

bind mtag_insert mtag_insert_chk #(.DATA_W(DATA_W), .TAG_W(TAG_W), .TAG_LSB(TAG_LSB)) u_chk (
  .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .tag_access_en_i(tag_access_en_i),
  .rand_mode_i(rand_mode_i), .sys_excl_i(sys_excl_i), .base_op_i(base_op_i),
  .excl_op_i(excl_op_i), .hit_o(hit_o), .rm_idx_o(rm_idx_o), .res_valid_o(res_valid_o),
  .result_o(result_o), .state_we_o(state_we_o), .state_o(state_o), .undef_o(undef_o)
);

// File: tb/mtag_insert_test.sv
`timescale 1ns/1ps
module mtag_insert_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        issue_i = 1'b0, feat_en_i = 1'b1, tag_access_en_i = 1'b1, rand_mode_i = 1'b0;
  logic [31:0] insn_i = '0;
  logic [15:0] sys_excl_i = '0;
  logic [63:0] base_op_i = '0, excl_op_i = '0;
  logic [3:0]  tag_state_i = '0;
  logic        hit_o, rd_is_sp_o, rn_is_sp_o, rm_is_zero_o, res_valid_o, state_we_o, undef_o;
  logic [4:0]  rd_idx_o, rn_idx_o, rm_idx_o;
  logic [63:0] result_o;
  logic [3:0]  state_o;

  mtag_insert uut (
    .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .insn_i(insn_i), .feat_en_i(feat_en_i),
    .tag_access_en_i(tag_access_en_i), .rand_mode_i(rand_mode_i), .sys_excl_i(sys_excl_i),
    .base_op_i(base_op_i), .excl_op_i(excl_op_i), .tag_state_i(tag_state_i),
    .hit_o(hit_o), .rd_idx_o(rd_idx_o), .rn_idx_o(rn_idx_o), .rm_idx_o(rm_idx_o),
    .rd_is_sp_o(rd_is_sp_o), .rn_is_sp_o(rn_is_sp_o), .rm_is_zero_o(rm_is_zero_o),
    .res_valid_o(res_valid_o), .result_o(result_o), .state_we_o(state_we_o),
    .state_o(state_o), .undef_o(undef_o)
  );

  int checks = 0, errs = 0, n_ops = 0;
  bit done = 1'b0;
  logic [15:0] m_lfsr = 16'hACE1;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] enc(input logic [4:0] rm, input logic [4:0] rn, input logic [4:0] rd);
    return {11'b10011010110, rm, 6'b000100, rn, rd};
  endfunction

  // first non-excluded tag at or above start, wrapping; none=1 if all excluded
  function automatic logic [4:0] pick_model(input logic [3:0] s, input logic [15:0] m);
    logic [4:0] r = 5'h10;
    for (int i = 15; i >= 0; i--) begin
      logic [3:0] c = s + 4'(i);
      if (!m[c]) r = {1'b0, c};
    end
    return r;
  endfunction

  task automatic exec(input logic [31:0] insn, input logic feat, input logic acc, input logic mode,
                      input logic [15:0] sys, input logic [63:0] excl, input logic [3:0] st);
    logic hit, we;
    logic [15:0] mask;
    logic [3:0] tag;
    logic [4:0] pk;
    logic [63:0] base, exp_res;
    n_ops++;
    base = 64'hF0F0_1234_5678_9ABC ^ (64'(n_ops) * 64'h9E37_79B9_7F4A_7C15);
    @(negedge clk);
    issue_i = 1'b1; insn_i = insn; feat_en_i = feat; tag_access_en_i = acc;
    rand_mode_i = mode; sys_excl_i = sys; excl_op_i = excl; tag_state_i = st; base_op_i = base;
    hit  = (insn[31:21] == 11'b10011010110) && (insn[15:10] == 6'b000100);
    mask = sys | ((insn[20:16] == 5'd31) ? 16'h0 : excl[15:0]);
    tag = 4'h0; we = 1'b0;
    if (acc) begin
      pk  = pick_model(mode ? m_lfsr[3:0] : st + m_lfsr[3:0], mask);
      tag = pk[4] ? 4'h0 : pk[3:0];
      we  = !mode;
    end
    exp_res = base;
    exp_res[59:56] = tag;
    @(posedge clk); #1;
    chk("R1 hit", 64'(hit_o), 64'(hit));
    chk("R1 fields", 64'({rm_idx_o, rn_idx_o, rd_idx_o}), 64'({insn[20:16], insn[9:5], insn[4:0]}));
    chk("R1 sp/zero flags", 64'({rd_is_sp_o, rn_is_sp_o, rm_is_zero_o}),
        64'({insn[4:0] == 5'd31, insn[9:5] == 5'd31, insn[20:16] == 5'd31}));
    if (hit && feat) begin
      chk("R3 valid", 64'(res_valid_o), 64'd1);
      chk("R3/R5/R6 result R2 mask", result_o, exp_res);
      chk("R4/R5/R6 state write", 64'(state_we_o), 64'(we));
      if (we) chk("R5 state value", 64'(state_o), 64'(tag));
      chk("R8 no undef", 64'(undef_o), 64'd0);
      m_lfsr = {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]}; // R7
    end else if (hit) begin
      chk("R8 undef", 64'(undef_o), 64'd1);
      chk("R8 no valid/write", 64'({res_valid_o, state_we_o}), 64'd0);
    end else begin
      chk("R9 silent", 64'({res_valid_o, undef_o, state_we_o}), 64'd0);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errs++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk); #1;
    chk("R3 reset outputs", 64'({res_valid_o, undef_o, state_we_o}), 64'd0);
    chk("R3 reset result", result_o, 64'd0);

    // R1: register index sweep, including stack pointer and zero-register indexes
    for (int i = 0; i < 32; i++)
      exec(enc(5'(i), 5'(31 - i), 5'(i)), 1'b1, 1'b1, 1'b0, 16'h0, 64'h0, 4'(i));

    // R5: every start state against single-free masks and the all-excluded mask
    for (int st = 0; st < 16; st++)
      for (int k = 0; k <= 16; k++) begin
        logic [15:0] m = (k < 16) ? ~(16'h1 << k) : 16'hFFFF;
        exec(enc(5'd3, 5'd4, 5'd5), 1'b1, 1'b1, 1'b0, m & 16'h0F0F,
             {48'hDEAD_BEEF_0000, m & 16'hF0F0}, 4'(st));
      end

    // R6: random mode over computed masks, plus all-excluded
    for (int k = 0; k < 40; k++) begin
      logic [15:0] m = 16'(k * 16'h9E37) ^ 16'(k << 3);
      exec(enc(5'd7, 5'd31, 5'd31), 1'b1, 1'b1, 1'b1, m, 64'(k) << 20, 4'(k));
    end
    exec(enc(5'd7, 5'd1, 5'd2), 1'b1, 1'b1, 1'b1, 16'hFF00, 64'h00FF, 4'h9);

    // R2: zero-register exclusion source ignores an all-ones operand
    for (int k = 0; k < 8; k++)
      exec(enc(5'd31, 5'd2, 5'd3), 1'b1, 1'b1, 1'b0, 16'h0, 64'hFFFF_FFFF_FFFF_FFFF, 4'(k));

    // R4: tag access disabled in both modes
    for (int k = 0; k < 6; k++)
      exec(enc(5'd1, 5'd2, 5'd3), 1'b1, 1'b0, 1'(k), 16'h0, 64'h0, 4'hF);

    // R8: feature disabled sits between executed ops; R7 seen via following tags
    for (int k = 0; k < 4; k++) begin
      exec(enc(5'd1, 5'd2, 5'd3), 1'b0, 1'b1, 1'b0, 16'h0, 64'h0, 4'h3);
      exec(enc(5'd1, 5'd2, 5'd3), 1'b1, 1'b1, 1'b1, 16'h0, 64'h0, 4'h3);
    end

    // R9: near-miss encodings
    for (int b = 10; b < 16; b++)
      exec(enc(5'd1, 5'd2, 5'd3) ^ (32'h1 << b), 1'b1, 1'b1, 1'b0, 16'h0, 64'h0, 4'h0);
    for (int b = 21; b < 32; b++)
      exec(enc(5'd1, 5'd2, 5'd3) ^ (32'h1 << b), 1'b1, 1'b1, 1'b0, 16'h0, 64'h0, 4'h0);
    exec(enc(5'd1, 5'd2, 5'd3), 1'b1, 1'b1, 1'b1, 16'h0, 64'h0, 4'h0); // R7 after misses

    @(negedge clk); issue_i = 1'b0;
    @(posedge clk); #1;
    chk("R9 idle", 64'({res_valid_o, undef_o, state_we_o}), 64'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end
endmodule